// File: doc/BRIEF.md
# Mailbox Message Controller

This block carries short messages from up to `NS` secondary functions to one primary function. Each secondary side writes the byte address of its message into a send-address pair. Writing the high half of that pair also supplies the message size and starts the transfer. A copy engine then moves the message, one 32-bit word per cycle, from the sender's region of a shared word-addressed memory into the receive buffer that the primary side has assigned to that sender. The sender's pending bit is raised only when the last word has landed.

The primary side sees one pending bit per sender and an interrupt line gated by a per-sender enable mask. It answers a message with a single write to the message-received register. That write clears the pending bit, frees the sender, and returns a 16-bit code plus a pass/fail flag. The shared memory is internal. A plain read/write port lets the surrounding logic load outgoing messages and inspect delivered ones while the engine is idle.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset every secondary status register reads 0, the primary message-received register reads 0, the enable and detect registers read 0, and `irq` is low.
- R2: A send whose size code is c (bits 4:0 of the secondary high-address write at 0x214) copies c×32 bytes, or 1024 bytes when c is 0. The data is copied word for word from the send byte address into the receive buffer, and the memory word just past the buffer is left unchanged.
- R3: Secondary status bit 0 (busy) reads 1 from the start write until the primary releases the message. Primary message-received bit n+1 (offset 0x204) for sender n rises only in the cycle after the engine writes that sender's last word.
- R4: A primary write to 0x204 that has bit n+1 set while sender n is pending clears that pending bit and busy. The same write places bits 31:16 into the sender's status bits 31:16 and bit 0 into status bit 1 (0 = success, 1 = failure). Writing bit n+1 when sender n is not pending has no effect.
- R5: While a sender is busy, its writes to 0x210 and 0x214 are ignored. This covers both a new start and a new address.
- R6: A start issued while the sender's receive address pair (primary 0x210+8n low, 0x214+8n high) is all zero completes at once. Status then reads busy 0, status bit 1 set, code 0, and no pending bit is raised.
- R7: When several senders wait for the engine, the lowest index is copied first.
- R8: Detect bit n+1 (primary 0x0A4) is set when sender n's copy completes and is cleared by writing 1 to it. Enable bits n+1 live at 0x0A0. `irq` is high exactly when some detect bit has its enable bit set.
- R9: Receive-address low registers read back with bits 4:0 forced to 0 (32-byte alignment). High registers read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p_we | input | 1 | Primary register write strobe |
| p_addr | input | RA_W | Primary register byte offset |
| p_wdata | input | 32 | Primary write data |
| p_rdata | output | 32 | Primary read data (combinational on p_addr) |
| s_we | input | NS | Per-sender register write strobe |
| s_addr | input | NS*RA_W | Per-sender register offsets, sender n in slice n |
| s_wdata | input | NS*32 | Per-sender write data |
| s_rdata | output | NS*32 | Per-sender read data |
| mem_we | input | 1 | Shared memory write strobe (ignored while copying) |
| mem_addr | input | MEM_AW | Shared memory word address |
| mem_wdata | input | 32 | Shared memory write data |
| mem_rdata | output | 32 | Shared memory read data |
| irq | output | 1 | Message-received interrupt |

## Verification
The bench uses the default build: two senders and a 1024-word memory. With this size the largest 1024-byte message and both receive buffers fit side by side. This lets the bench sweep all 32 size codes on one sender and check each copy word by word, including the guard word past the end. Two senders are enough to start both in the same cycle, which exercises the fixed copy order, and to clear one sender while the other is still being copied.

// File: rtl/mbox_ctrl.sv
module mbox_ctrl #(
  parameter int NS        = 2,
  parameter int MEM_AW    = 10,
  parameter int RA_W      = 12,
  parameter int MAX_BYTES = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 p_we,
  input  logic [RA_W-1:0]      p_addr,
  input  logic [31:0]          p_wdata,
  output logic [31:0]          p_rdata,
  input  logic [NS-1:0]        s_we,
  input  logic [NS*RA_W-1:0]   s_addr,
  input  logic [NS*32-1:0]     s_wdata,
  output logic [NS*32-1:0]     s_rdata,
  input  logic                 mem_we,
  input  logic [MEM_AW-1:0]    mem_addr,
  input  logic [31:0]          mem_wdata,
  output logic [31:0]          mem_rdata,
  output logic                 irq
);
  localparam int IDW  = NS > 1 ? $clog2(NS) : 1;
  localparam int MAXW = MAX_BYTES / 4;
  localparam int CW   = $clog2(MAXW);
  localparam int SZW  = $clog2(MAX_BYTES / 32);
  localparam logic [RA_W-1:0] A_MSG  = RA_W'(32'h204);
  localparam logic [RA_W-1:0] A_SLO  = RA_W'(32'h210);
  localparam logic [RA_W-1:0] A_SHI  = RA_W'(32'h214);
  localparam logic [RA_W-1:0] A_IEN  = RA_W'(32'h0A0);
  localparam logic [RA_W-1:0] A_IDET = RA_W'(32'h0A4);

  logic [31:0] snd_lo [NS];
  logic [31:0] snd_hi [NS];
  logic [31:0] rx_lo  [NS];
  logic [31:0] rx_hi  [NS];
  logic [15:0] code   [NS];
  logic [NS-1:0] busy, stat, req, pend, ien, idet;

  logic              active;
  logic [IDW-1:0]    cur, sel;
  logic [MEM_AW-1:0] src, dst;
  logic [CW-1:0]     left;
  logic [SZW-1:0]    szc;
  logic [31:0]       mem [1<<MEM_AW];

  always_comb begin
    sel = '0;
    for (int n = NS-1; n >= 0; n--)
      if (req[n]) sel = IDW'(n);
  end

  assign szc = snd_hi[sel][SZW-1:0];
  assign irq = |(idet & ien);
  assign mem_rdata = mem[mem_addr];

  always_ff @(posedge clk) begin
    if (active) mem[dst] <= mem[src];
    else if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NS; n++) begin
        snd_lo[n] <= '0; snd_hi[n] <= '0;
        rx_lo[n]  <= '0; rx_hi[n]  <= '0;
        code[n]   <= '0;
      end
      busy <= '0; stat <= '0; req <= '0; pend <= '0;
      ien <= '0; idet <= '0;
      active <= 1'b0; cur <= '0; src <= '0; dst <= '0; left <= '0;
    end else begin
      for (int n = 0; n < NS; n++) begin
        if (s_we[n] && !busy[n]) begin
          if (s_addr[n*RA_W +: RA_W] == A_SLO)
            snd_lo[n] <= {s_wdata[n*32+5 +: 27], 5'b0};
          if (s_addr[n*RA_W +: RA_W] == A_SHI) begin
            snd_hi[n] <= s_wdata[n*32 +: 32];
            if (rx_lo[n] == '0 && rx_hi[n] == '0) begin
              stat[n] <= 1'b1;
              code[n] <= '0;
            end else begin
              busy[n] <= 1'b1;
              req[n]  <= 1'b1;
            end
          end
        end
      end

      if (p_we) begin
        if (p_addr == A_MSG)
          for (int n = 0; n < NS; n++)
            if (p_wdata[n+1] && pend[n]) begin
              pend[n] <= 1'b0;
              busy[n] <= 1'b0;
              code[n] <= p_wdata[31:16];
              stat[n] <= p_wdata[0];
            end
        if (p_addr == A_IEN)  ien  <= p_wdata[NS:1];
        if (p_addr == A_IDET) idet <= idet & ~p_wdata[NS:1];
        for (int n = 0; n < NS; n++) begin
          if (p_addr == RA_W'(32'h210 + 32'(8*n))) rx_lo[n] <= {p_wdata[31:5], 5'b0};
          if (p_addr == RA_W'(32'h214 + 32'(8*n))) rx_hi[n] <= p_wdata;
        end
      end

      if (!active) begin
        if (|req) begin
          active   <= 1'b1;
          cur      <= sel;
          req[sel] <= 1'b0;
          src      <= snd_lo[sel][MEM_AW+1:2];
          dst      <= rx_lo[sel][MEM_AW+1:2];
          left     <= (szc == '0) ? CW'(MAXW-1) : CW'({szc, 3'b000} - 1);
        end
      end else begin
        src  <= src + 1'b1;
        dst  <= dst + 1'b1;
        left <= left - 1'b1;
        if (left == '0) begin
          active    <= 1'b0;
          pend[cur] <= 1'b1;
          idet[cur] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    p_rdata = '0;
    if (p_addr == A_MSG)  p_rdata = 32'({pend, 1'b0});
    if (p_addr == A_IEN)  p_rdata = 32'({ien, 1'b0});
    if (p_addr == A_IDET) p_rdata = 32'({idet, 1'b0});
    for (int n = 0; n < NS; n++) begin
      if (p_addr == RA_W'(32'h210 + 32'(8*n))) p_rdata = rx_lo[n];
      if (p_addr == RA_W'(32'h214 + 32'(8*n))) p_rdata = rx_hi[n];
    end
  end

  always_comb begin
    s_rdata = '0;
    for (int n = 0; n < NS; n++) begin
      if (s_addr[n*RA_W +: RA_W] == A_MSG) s_rdata[n*32 +: 32] = {code[n], 14'b0, stat[n], busy[n]};
      if (s_addr[n*RA_W +: RA_W] == A_SLO) s_rdata[n*32 +: 32] = snd_lo[n];
      if (s_addr[n*RA_W +: RA_W] == A_SHI) s_rdata[n*32 +: 32] = snd_hi[n];
    end
  end
endmodule

module mbox_ctrl_chk #(
  parameter int NS  = 2,
  parameter int IDW = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           active,
  input logic [IDW-1:0] cur,
  input logic [NS-1:0]  req,
  input logic [NS-1:0]  pend,
  input logic [NS-1:0]  busy,
  input logic [NS-1:0]  idet,
  input logic [NS-1:0]  s_we,
  input logic [31:0]    snd_hi [NS]
);
  p_pend_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~busy) == '0);

  p_first_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active) && $past(req[0])) |-> cur == '0);

  for (genvar n = 0; n < NS; n++) begin : g_snd
    p_pend_after_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[n]) |-> ($past(active) && $past(cur) == IDW'(n)));

    p_busy_ignores_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (s_we[n] && busy[n]) |=> $stable(snd_hi[n]));

    p_detect_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idet[n]) |-> $rose(pend[n]));
  end
endmodule

bind mbox_ctrl mbox_ctrl_chk #(.NS(NS), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .cur(cur), .req(req),
  .pend(pend), .busy(busy), .idet(idet), .s_we(s_we), .snd_hi(snd_hi)
);

// File: tb/tb_mbox_ctrl.sv
`timescale 1ns/1ps
module tb_mbox_ctrl;
  localparam int NS = 2, AW = 10, RW = 12;
  logic clk = 0, rst_n = 0;
  logic p_we = 0; logic [RW-1:0] p_addr = '0; logic [31:0] p_wdata = '0, p_rdata;
  logic [NS-1:0] s_we = '0; logic [NS*RW-1:0] s_addr = '0;
  logic [NS*32-1:0] s_wdata = '0, s_rdata;
  logic mem_we = 0; logic [AW-1:0] mem_addr = '0; logic [31:0] mem_wdata = '0, mem_rdata;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 0;

  mbox_ctrl dut (.clk, .rst_n, .p_we, .p_addr, .p_wdata, .p_rdata, .s_we, .s_addr,
                 .s_wdata, .s_rdata, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .irq);

  always #2.5 clk = ~clk;

  function automatic logic [31:0] pat(input int i, input int c);
    return (32'(i) * 32'h9E3779B1) ^ (32'(c) << 20) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic pw(input logic [RW-1:0] a, input logic [31:0] d);
    @(negedge clk); p_we = 1; p_addr = a; p_wdata = d;
    @(negedge clk); p_we = 0;
  endtask

  task automatic sw(input int n, input logic [RW-1:0] a, input logic [31:0] d);
    @(negedge clk); s_we[n] = 1; s_addr[n*RW +: RW] = a; s_wdata[n*32 +: 32] = d;
    @(negedge clk); s_we[n] = 0;
  endtask

  task automatic prd(input logic [RW-1:0] a, output logic [31:0] d);
    p_addr = a; #0.1; d = p_rdata;
  endtask

  task automatic srd(input int n, input logic [RW-1:0] a, output logic [31:0] d);
    s_addr[n*RW +: RW] = a; #0.1; d = s_rdata[n*32 +: 32];
  endtask

  task automatic fill(input int base, input int cnt, input int c, input bit inv);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk); mem_we = 1; mem_addr = AW'(base + i);
      mem_wdata = inv ? ~pat(i, c) : pat(i, c);
    end
    @(negedge clk); mem_we = 0;
  endtask

  task automatic wait_pend(input logic [31:0] mask);
    logic [31:0] d;
    for (int k = 0; k < 600; k++) begin
      prd(12'h204, d);
      if ((d & mask) == mask) break;
      @(negedge clk);
    end
  endtask

  // counts mismatches in a delivered buffer, including the guard word after it
  task automatic cmp(input int base, input int words, input int c, input int span, output int bad);
    bad = 0;
    for (int i = 0; i < span; i++) begin
      mem_addr = AW'(base + i); #0.1;
      if (mem_rdata !== ((i < words) ? pat(i, c) : ~pat(i, c))) bad++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int bad, w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    srd(0, 12'h204, d); chk("R1 s0 status", d, 0);
    srd(1, 12'h204, d); chk("R1 s1 status", d, 0);
    prd(12'h204, d); chk("R1 pending", d, 0);
    prd(12'h0A0, d); chk("R1 enable", d, 0);
    prd(12'h0A4, d); chk("R1 detect", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R9 receive address registers
    pw(12'h210, 32'h0000_081F); prd(12'h210, d); chk("R9 rx0 lo aligned", d, 32'h800);
    pw(12'h214, 32'h0000_0000); prd(12'h214, d); chk("R9 rx0 hi", d, 0);
    pw(12'h218, 32'h0000_0C00); prd(12'h218, d); chk("R9 rx1 lo", d, 32'hC00);
    pw(12'h21C, 32'hA5A5_0000); prd(12'h21C, d); chk("R9 rx1 hi", d, 32'hA5A5_0000);
    pw(12'h0A0, 32'h6);

    // R2/R3/R4/R8 sweep over every size code on sender 0
    for (int c = 0; c < 32; c++) begin
      w = (c == 0) ? 256 : c * 8;
      fill(0, 256, c, 0);
      fill(512, 256, c, 1);
      sw(0, 12'h210, 32'h0);
      sw(0, 12'h214, 32'(c));
      srd(0, 12'h204, d); chk("R3 busy after start", d & 1, 1);
      prd(12'h204, d); chk("R3 not pending during copy", d, 0);
      wait_pend(32'h2);
      prd(12'h204, d); chk("R3 pending after copy", d, 32'h2);
      chk("R8 irq on completion", {31'b0, irq}, 1);
      cmp(512, w, c, (w < 256) ? w + 1 : 256, bad);
      chk("R2 copied words", 32'(bad), 0);
      pw(12'h204, {16'(c * 3 + 1), 14'b0, 1'b1, 1'(c & 1)});
      srd(0, 12'h204, d); chk("R4 status after release", d, {16'(c * 3 + 1), 14'b0, 1'(c & 1), 1'b0});
      prd(12'h204, d); chk("R4 pending cleared", d, 0);
      pw(12'h0A4, 32'h6);
      chk("R8 irq after detect clear", {31'b0, irq}, 0);
    end

    // R5: writes while busy are ignored
    fill(0, 16, 7, 0);
    fill(768, 16, 7, 1);
    sw(1, 12'h210, 32'h0);
    sw(1, 12'h214, 32'h1);
    sw(1, 12'h210, 32'h40);
    sw(1, 12'h214, 32'h5);
    srd(1, 12'h210, d); chk("R5 send low unchanged", d, 0);
    srd(1, 12'h214, d); chk("R5 send high unchanged", d, 1);
    wait_pend(32'h4);
    cmp(768, 8, 7, 9, bad); chk("R5 only first send copied", 32'(bad), 0);
    pw(12'h204, 32'h0000_0004);
    pw(12'h0A4, 32'h6);

    // R6: zero receive address fails at once
    pw(12'h210, 32'h0);
    sw(0, 12'h214, 32'h2);
    srd(0, 12'h204, d); chk("R6 immediate failure", d, 32'h0000_0002);
    prd(12'h204, d); chk("R6 no pending", d, 0);
    pw(12'h210, 32'h800);

    // R7 and R4: simultaneous starts, lowest index first
    @(negedge clk);
    s_we = 2'b11;
    s_addr = {12'h214, 12'h214};
    s_wdata = {32'h2, 32'h2};
    @(negedge clk); s_we = 0;
    wait_pend(32'h2);
    prd(12'h204, d); chk("R7 sender 0 first", d, 32'h2);
    pw(12'h204, 32'h0000_0004);
    srd(1, 12'h204, d); chk("R4 clearing idle bit has no effect", d & 1, 1);
    wait_pend(32'h6);
    prd(12'h204, d); chk("R7 sender 1 next", d, 32'h6);
    pw(12'h204, 32'h0042_0006);
    srd(1, 12'h204, d); chk("R4 code to sender 1", d, 32'h0042_0000);

    // R8: masked detect does not raise irq
    pw(12'h0A4, 32'h6);
    pw(12'h0A0, 32'h0);
    sw(0, 12'h214, 32'h1);
    wait_pend(32'h2);
    prd(12'h0A4, d); chk("R8 detect set while masked", d, 32'h2);
    chk("R8 irq masked", {31'b0, irq}, 0);
    pw(12'h0A0, 32'h2);
    chk("R8 irq unmasked", {31'b0, irq}, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule